// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Match Alarm

This peripheral keeps time as a plain 32-bit count of whole seconds. A free-running prescaler divides the bus clock into a one-cycle tick once per second. On each tick the seconds counter either takes a new time value or steps forward by one. Software sets a new time by writing a staging register. That value reaches the counter only at the next tick, so the visible time never changes between one-second boundaries.

A match register is compared with the counter each time the counter takes a new value. An equal value sets a sticky raw alarm flag. The alarm output and the masked status bit are that flag qualified by an enable bit and a mask bit. Software acknowledges the alarm by reading a dedicated acknowledge register, which clears the flag as a side effect. A control bit selects whether the counter rolls over to zero after 0xFFFFFFFF or stops there.

The bus is a simple single-cycle register port. The offset is decoded from a word-aligned byte address, and read data is registered, so it is valid one clock after the read strobe.

Top module: `sec_rtc`

## Requirements
- R1: After reset every register reads zero except the identity register at offset 0x1C, which reads the VERSION parameter, and `alarm_irq` is low.
- R2: While control bit 2 (run) is set, the counter at offset 0x00 increases by exactly one every TICK_DIV clock cycles.
- R3: While control bit 2 is clear, the counter holds its value across ticks.
- R4: A write to the staging register at 0x08 leaves the counter unchanged until the next tick. On that tick the counter takes the staged value, whether or not the run bit is set, and normal counting resumes afterwards. Offset 0x08 reads back the last value written.
- R5: With control bit 3 (roll-over) clear, the counter stays at 0xFFFFFFFF. With it set, the counter moves from 0xFFFFFFFF to 0 on the next tick.
- R6: When the counter takes a value equal to the match register at 0x04, bit 0 of the raw status at 0x14 becomes 1 and stays 1, independent of control bits 0 and 1.
- R7: `alarm_irq` and bit 0 of the masked status at 0x10 both equal raw status AND control bit 0 (enable) AND NOT control bit 1 (mask).
- R8: A read of offset 0x18 returns the raw status in bit 0 and clears the raw status, which drops `alarm_irq`.
- R9: Writes to offsets 0x00, 0x10, 0x14, 0x18 and 0x1C change nothing. The control register at 0x0C reads back bits 3:0 with all higher bits zero.
- R10: `bus_rdata` holds the addressed register's value in the clock cycle after the one in which `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the prescaler input |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register (word aligned) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
The assertions assume TICK_DIV is at least 2, so two ticks are never adjacent. They also assume that a staging write landing exactly on a tick may leave the pending flag set. The checks on reload and clearing therefore exclude a write in that cycle. The bench keeps its accesses word aligned and drives one strobe per cycle. It measures tick timing only from the counter changes it observes, so it never relies on knowing the prescaler phase.

// File: rtl/rtc_pkg.sv
// Package: shared offsets, control bit positions and control type for the
// seconds RTC. Assumes 32-bit registers on a word-aligned byte address.
package rtc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    // Register index (byte address bits 4:2)
    localparam logic [2:0] IDX_TIME   = 3'd0;
    localparam logic [2:0] IDX_MATCH  = 3'd1;
    localparam logic [2:0] IDX_STAGE  = 3'd2;
    localparam logic [2:0] IDX_CTRL   = 3'd3;
    localparam logic [2:0] IDX_MSTAT  = 3'd4;
    localparam logic [2:0] IDX_RSTAT  = 3'd5;
    localparam logic [2:0] IDX_ACK    = 3'd6;
    localparam logic [2:0] IDX_IDENT  = 3'd7;

    // Control bits, msb first: roll-over, run, mask, enable
    typedef struct packed {
        logic rollover;
        logic run;
        logic mask;
        logic irq_en;
    } rtc_ctrl_t;

    localparam int CTRL_W = 4;
endpackage

// File: rtl/rtc_tick_gen.sv
// Prescaler: divides the bus clock by DIV and gives a one-cycle tick on the
// last count of each period. Free-running from reset; assumes DIV >= 2.
module rtc_tick_gen #(
    parameter int DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    // Count through one second's worth of clocks, then start over
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/rtc_sec_counter.sv
// Seconds counter with staged load. A staging write marks a load pending;
// the next tick applies it in place of an increment. Increments need run;
// at the all-ones value the counter rolls only when rollover is set.
// upd pulses the cycle after the counter takes a new value.
module rtc_sec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         rollover,
    input  logic         stage_wr,
    input  logic [W-1:0] stage_data,
    output logic [W-1:0] count,
    output logic [W-1:0] stage_val,
    output logic         pending,
    output logic         upd
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic at_top;
    logic step_ok;
    logic take;

    assign at_top  = (count == TOP);
    assign step_ok = run && !(at_top && !rollover);
    assign take    = tick && (pending || step_ok);

    // Hold the staged time value written by software
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_val <= '0;
        else if (stage_wr)
            stage_val <= stage_data;
    end

    // Pending flag: set by a staging write, cleared when a tick applies it
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (stage_wr)
            pending <= 1'b1;
        else if (tick)
            pending <= 1'b0;
    end

    // Counter: on a tick either load the staged value or advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick && pending)
            count <= stage_val;
        else if (tick && step_ok)
            count <= count + 1'b1;
    end

    // Strobe marking that the counter has just taken a new value
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd <= 1'b0;
        else
            upd <= take;
    end
endmodule

// File: rtl/rtc_alarm.sv
// Alarm: compares the counter with the match value when the counter has
// just updated, sets a sticky raw flag, gates it with enable and mask.
// An acknowledge read clears the flag; a new hit in that cycle wins.
module rtc_alarm #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] count,
    input  logic [W-1:0] match,
    input  logic         irq_en,
    input  logic         mask,
    input  logic         ack_rd,
    output logic         raw,
    output logic         irq
);
    logic hit;

    assign hit = upd && (count == match);

    // Sticky raw alarm flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw <= 1'b0;
        else if (hit)
            raw <= 1'b1;
        else if (ack_rd)
            raw <= 1'b0;
    end

    assign irq = raw && irq_en && !mask;
endmodule

// File: rtl/sec_rtc.sv
// Top: register port, control and match registers, read mux, and the
// prescaler, counter and alarm instances. Assumes one strobe per cycle and
// word-aligned addresses; misaligned accesses are ignored.
module sec_rtc #(
    parameter int          TICK_DIV = 50_000_000,
    parameter logic [31:0] VERSION  = 32'h0001_0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        alarm_irq
);
    import rtc_pkg::*;

    logic [2:0]        idx;
    logic              aligned;
    logic              wr_ok;
    logic              rd_ok;
    rtc_ctrl_t         ctrl;
    logic [DATA_W-1:0] match_val;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] stage_val;
    logic              pending;
    logic              upd;
    logic              tick;
    logic              raw;
    logic              irq;
    logic              stage_wr;
    logic              ack_rd;
    logic [DATA_W-1:0] rd_mux;

    assign idx      = bus_addr[4:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_ok    = bus_wr && aligned;
    assign rd_ok    = bus_rd && aligned;
    assign stage_wr = wr_ok && (idx == IDX_STAGE);
    assign ack_rd   = rd_ok && (idx == IDX_ACK);

    // Control register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_ok && idx == IDX_CTRL)
            ctrl <= rtc_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // Match register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_val <= '0;
        else if (wr_ok && idx == IDX_MATCH)
            match_val <= bus_wdata;
    end

    rtc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    rtc_sec_counter #(.W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (ctrl.run),
        .rollover  (ctrl.rollover),
        .stage_wr  (stage_wr),
        .stage_data(bus_wdata),
        .count     (count),
        .stage_val (stage_val),
        .pending   (pending),
        .upd       (upd)
    );

    rtc_alarm #(.W(DATA_W)) u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .count (count),
        .match (match_val),
        .irq_en(ctrl.irq_en),
        .mask  (ctrl.mask),
        .ack_rd(ack_rd),
        .raw   (raw),
        .irq   (irq)
    );

    // Select the addressed register for reading
    always_comb begin
        case (idx)
            IDX_TIME:  rd_mux = count;
            IDX_MATCH: rd_mux = match_val;
            IDX_STAGE: rd_mux = stage_val;
            IDX_CTRL:  rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            IDX_MSTAT: rd_mux = {{(DATA_W-1){1'b0}}, irq};
            IDX_RSTAT: rd_mux = {{(DATA_W-1){1'b0}}, raw};
            IDX_ACK:   rd_mux = {{(DATA_W-1){1'b0}}, raw};
            default:   rd_mux = VERSION;
        endcase
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_ok)
            bus_rdata <= rd_mux;
    end

    assign alarm_irq = irq;
endmodule

// File: rtl/sec_rtc_checker.sv
// Checker for sec_rtc, bound into the top. Assumes TICK_DIV >= 2.
module sec_rtc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        pending,
    input logic        stage_wr,
    input logic        run,
    input logic        rollover,
    input logic        upd,
    input logic        raw,
    input logic        ack_rd,
    input logic        alarm_irq,
    input logic [31:0] count,
    input logic [31:0] stage_val,
    input logic [31:0] match_val
);
    // Ticks are single-cycle pulses (R2)
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // Counter only moves on a tick (R3)
    assert_still_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    // Pending load is applied at the tick (R4)
    assert_load_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pending) |=> (count == $past(stage_val)));

    // Pending clears after the tick unless rewritten (R4)
    assert_pending_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pending && !stage_wr) |=> !pending);

    // No roll-over when disabled (R5)
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pending && !rollover && count == 32'hFFFF_FFFF) |=> (count == 32'hFFFF_FFFF));

    // Run clear freezes counter without a pending load (R3)
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !pending && !stage_wr) |=> $stable(count));

    // Match at update sets raw status (R6)
    assert_match_sets_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && count == match_val) |=> raw);

    // Acknowledge read clears raw status (R8)
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !(upd && count == match_val)) |=> !raw);

    // Interrupt never without raw status (R7)
    assert_irq_needs_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> raw);
endmodule

bind sec_rtc sec_rtc_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pending  (pending),
    .stage_wr (stage_wr),
    .run      (ctrl.run),
    .rollover (ctrl.rollover),
    .upd      (upd),
    .raw      (raw),
    .ack_rd   (ack_rd),
    .alarm_irq(alarm_irq),
    .count    (count),
    .stage_val(stage_val),
    .match_val(match_val)
);

// File: tb/sec_rtc_tb_top.sv
`timescale 1ns/1ps
module sec_rtc_tb_top;
    localparam int          DIV = 10;
    localparam logic [31:0] VER = 32'hA5C3_0107;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sec_rtc #(.TICK_DIV(DIV), .VERSION(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // One cycle per read: strobe, then sample at the next falling edge (R10)
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_change(input logic [31:0] old, output logic [31:0] nv, output longint at);
        nv = old;
        at = 0;
        for (int i = 0; i < 8 * DIV; i++) begin
            rd(5'h00, nv);
            if (nv != old) begin
                at = cyc;
                return;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 7; i++) begin
            rd(5'(i * 4), v);
            check("R1 reset value", v, 32'h0);
        end
        rd(5'h1C, v);
        check("R1 version", v, VER);
        check("R1 irq low", {31'h0, alarm_irq}, 32'h0);
    endtask

    task automatic t_ignored_writes();
        logic [31:0] v;
        wr(5'h00, 32'h1234_5678);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'h0);
        repeat (2 * DIV) @(negedge clk);
        rd(5'h00, v); check("R9 time not writable / R3 stopped", v, 32'h0);
        rd(5'h14, v); check("R9 raw not writable", v, 32'h0);
        rd(5'h1C, v); check("R9 version fixed", v, VER);
        wr(5'h0C, 32'hFFFF_FFF0);
        rd(5'h0C, v); check("R9 ctrl upper bits zero", v, 32'h0);
    endtask

    task automatic t_load_and_count();
        logic [31:0] v, n;
        longint t1, t2;
        wr(5'h08, 32'h0000_1000);
        rd(5'h00, v); check("R4 load not immediate", v, 32'h0);
        rd(5'h08, v); check("R4 stage readback", v, 32'h0000_1000);
        wait_change(32'h0, n, t1);
        check("R4 load applied while stopped", n, 32'h0000_1000);
        repeat (2 * DIV) @(negedge clk);
        rd(5'h00, v); check("R3 stopped after load", v, 32'h0000_1000);
        wr(5'h0C, 32'h4);
        wait_change(32'h0000_1000, n, t1);
        check("R2 step one", n, 32'h0000_1001);
        wait_change(n, v, t2);
        check("R2 step two", v, 32'h0000_1002);
        check("R2 period", 32'(t2 - t1), 32'(DIV));
    endtask

    task automatic t_rollover();
        logic [31:0] v, n;
        longint t;
        wr(5'h0C, 32'h4);
        rd(5'h00, v);
        wr(5'h08, 32'hFFFF_FFFE);
        wait_change(v, n, t);
        check("R4 load while running", n, 32'hFFFF_FFFE);
        wait_change(n, v, t);
        check("R5 reach max", v, 32'hFFFF_FFFF);
        repeat (3 * DIV) @(negedge clk);
        rd(5'h00, v); check("R5 hold at max", v, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hC);
        wait_change(32'hFFFF_FFFF, n, t);
        check("R5 roll to zero", n, 32'h0);
    endtask

    task automatic t_alarm(input logic [31:0] ctl, input logic exp_irq, input string tag);
        logic [31:0] v, n;
        longint t;
        wr(5'h0C, 32'h0);
        wr(5'h04, 32'h0000_0502);
        wr(5'h08, 32'h0000_0500);
        wr(5'h0C, ctl);
        v = 32'hDEAD_BEEF;
        for (int k = 0; k < 6 && v != 32'h0000_0502; k++) wait_change(v, v, t);
        check({tag, " R6 reached match"}, v, 32'h0000_0502);
        repeat (2) @(negedge clk);
        rd(5'h14, n); check({tag, " R6 raw set"}, n, 32'h1);
        rd(5'h10, n); check({tag, " R7 masked status"}, n, {31'h0, exp_irq});
        check({tag, " R7 irq pin"}, {31'h0, alarm_irq}, {31'h0, exp_irq});
        rd(5'h18, n); check({tag, " R8 ack returns raw"}, n, 32'h1);
        check({tag, " R8 irq dropped"}, {31'h0, alarm_irq}, 32'h0);
        rd(5'h14, n); check({tag, " R8 raw cleared"}, n, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ignored_writes();
        t_load_and_count();
        t_rollover();
        t_alarm(32'h5, 1'b1, "enabled");
        t_alarm(32'h7, 1'b0, "masked");
        t_alarm(32'h4, 1'b0, "disabled");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule